// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the state updates a 32-bit in-order core with a branch delay slot needs when it starts an exception handler. Each cycle it takes at most one request. A request carries an exception code, an effective address, the current program counter, a flag that marks an instruction in a delay slot, and the live status word. If the code is recognised and the debug side does not veto it, the block commits the whole entry on one clock edge. It writes the handler address into the fetch pointers, saves the faulting address, a snapshot of the status word and the return address, and writes the supervisor-mode status word.

The handler address is the exception code shifted left by eight bits. A status bit can relocate it into the top of the address map. The saved return address depends on the class of the exception. It steps back one instruction when the faulting instruction sits in a delay slot, so that the branch is re-executed on return. A one-cycle pulse shows that an entry was committed.

Top module: `exc_entry_unit`

## Requirements
- R1: The handler address is `req_code << 8`, plus 0xF000_0000 when bit 14 of `sr_in` is set. For a non-interrupt entry, `pc_o` takes `cur_pc` and `npc_o` takes the handler address.
- R2: On entry, `eear_o` takes `req_ea` and `esr_o` takes `sr_in` exactly as presented, before any rewrite.
- R3: On entry, `sr_o` is `sr_in` with bit 0 set and bits 1, 2, 5, 6 and 12 cleared. Every other bit is copied unchanged.
- R4: Code 0x1 (reset) leaves `epcr_o` unchanged.
- R5: Codes 0x4 (instruction page fault) and 0xA (instruction TLB miss) load `epcr_o` with `req_ea`, minus 4 when `in_dslot` is high.
- R6: Codes 0x2, 0x3, 0x6, 0x7, 0x9, 0xB and 0xE load `epcr_o` with `cur_pc`, minus 4 when `in_dslot` is high.
- R7: Code 0xC (system call) loads `epcr_o` with `cur_pc + 4`, minus 4 when `in_dslot` is high.
- R8: Codes 0x5 (tick) and 0x8 (external interrupt) load `epcr_o` with `cur_pc`, minus 4 when `in_dslot` is high. They set `pc_o` to the handler address and `npc_o` to the handler address plus 4.
- R9: `dslot_o` is 0 in the cycle after an entry. In any other cycle it shows `in_dslot` from the cycle before.
- R10: A request with `dbg_suppress` high changes none of `pc_o`, `npc_o`, `sr_o`, `epcr_o`, `eear_o`, `esr_o`, and `pending_o` stays low.
- R11: Requests with codes 0x0, 0xD or 0xF are ignored in the same way as R10.
- R12: `pending_o` is high for exactly the one cycle after an accepted request. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request present this cycle |
| req_code | input | 4 | Exception code (vector offset / 0x100) |
| req_ea | input | 32 | Effective address tied to the request |
| cur_pc | input | 32 | Program counter of the current instruction |
| in_dslot | input | 1 | Current instruction is in a delay slot |
| dbg_suppress | input | 1 | Debug side vetoes this request |
| sr_in | input | 32 | Live status word |
| pc_o | output | 32 | Program counter after entry |
| npc_o | output | 32 | Next program counter after entry |
| sr_o | output | 32 | Rewritten status word |
| epcr_o | output | 32 | Saved return address |
| eear_o | output | 32 | Saved effective address |
| esr_o | output | 32 | Saved status word |
| dslot_o | output | 1 | Delay-slot flag seen by the next instruction |
| pending_o | output | 1 | Entry committed last cycle |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and status word, 4-byte instructions, and a high vector base of 0xF000_0000. At these values, codes in the plain-offset range can be checked with the relocation bit both clear and set. The bench also drives a program counter near zero, so that the delay-slot correction of the return address wraps. Every code class is run both inside and outside a delay slot. Debug vetoes and unknown codes are sent with state already loaded, so that an unwanted write would show on the ports.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int CODE_W = 4;

  // status-word bit positions
  localparam int SRB_SUPV  = 0;
  localparam int SRB_TICKE = 1;
  localparam int SRB_INTE  = 2;
  localparam int SRB_DMMU  = 5;
  localparam int SRB_IMMU  = 6;
  localparam int SRB_OVFE  = 12;
  localparam int SRB_VHIGH = 14;

  // exception codes (vector offset divided by 0x100)
  localparam logic [CODE_W-1:0] XC_RESET = 4'h1;
  localparam logic [CODE_W-1:0] XC_BUS   = 4'h2;
  localparam logic [CODE_W-1:0] XC_DPF   = 4'h3;
  localparam logic [CODE_W-1:0] XC_IPF   = 4'h4;
  localparam logic [CODE_W-1:0] XC_TICK  = 4'h5;
  localparam logic [CODE_W-1:0] XC_ALIGN = 4'h6;
  localparam logic [CODE_W-1:0] XC_ILL   = 4'h7;
  localparam logic [CODE_W-1:0] XC_EXT   = 4'h8;
  localparam logic [CODE_W-1:0] XC_DTLB  = 4'h9;
  localparam logic [CODE_W-1:0] XC_ITLB  = 4'hA;
  localparam logic [CODE_W-1:0] XC_RANGE = 4'hB;
  localparam logic [CODE_W-1:0] XC_SCALL = 4'hC;
  localparam logic [CODE_W-1:0] XC_TRAP  = 4'hE;

  // where the saved return address comes from
  typedef enum logic [1:0] {
    RET_KEEP   = 2'd0,
    RET_EA     = 2'd1,
    RET_PC     = 2'd2,
    RET_PCNEXT = 2'd3
  } ret_src_e;

  typedef struct packed {
    logic     known;
    logic     async_irq;
    ret_src_e ret_src;
  } exc_class_t;

endpackage

// File: rtl/exc_class_decode.sv
module exc_class_decode
  import exc_entry_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output exc_class_t        cls
);

  always_comb begin
    cls.known     = 1'b1;
    cls.async_irq = 1'b0;
    cls.ret_src   = RET_KEEP;
    case (code)
      XC_RESET: cls.ret_src = RET_KEEP;
      XC_IPF, XC_ITLB: cls.ret_src = RET_EA;
      XC_BUS, XC_DPF, XC_ALIGN, XC_ILL, XC_DTLB, XC_RANGE, XC_TRAP:
        cls.ret_src = RET_PC;
      XC_SCALL: cls.ret_src = RET_PCNEXT;
      XC_TICK, XC_EXT: begin
        cls.ret_src   = RET_PC;
        cls.async_irq = 1'b1;
      end
      default: cls.known = 1'b0;
    endcase
  end

endmodule

// File: rtl/exc_ret_addr.sv
module exc_ret_addr
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input  ret_src_e          src,
  input  logic [ADDR_W-1:0] ea,
  input  logic [ADDR_W-1:0] pc,
  input  logic              dslot,
  output logic              wr_en,
  output logic [ADDR_W-1:0] ret_addr
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  logic [ADDR_W-1:0] base;

  always_comb begin
    case (src)
      RET_EA:     base = ea;
      RET_PC:     base = pc;
      RET_PCNEXT: base = pc + STEP;
      default:    base = pc;
    endcase
    wr_en    = (src != RET_KEEP);
    ret_addr = dslot ? (base - STEP) : base;
  end

endmodule

// File: rtl/exc_sr_rewrite.sv
module exc_sr_rewrite
  import exc_entry_pkg::*;
#(
  parameter int SR_W = 32
) (
  input  logic [SR_W-1:0] sr_cur,
  output logic [SR_W-1:0] sr_new
);

  localparam logic [SR_W-1:0] FORCE_ONE  = SR_W'(1) << SRB_SUPV;
  localparam logic [SR_W-1:0] FORCE_ZERO = (SR_W'(1) << SRB_TICKE) |
                                           (SR_W'(1) << SRB_INTE)  |
                                           (SR_W'(1) << SRB_DMMU)  |
                                           (SR_W'(1) << SRB_IMMU)  |
                                           (SR_W'(1) << SRB_OVFE);

  for (genvar i = 0; i < SR_W; i++) begin : g_bit
    if (FORCE_ONE[i]) begin : g_one
      assign sr_new[i] = 1'b1;
    end else if (FORCE_ZERO[i]) begin : g_zero
      assign sr_new[i] = 1'b0;
    end else begin : g_keep
      assign sr_new[i] = sr_cur[i];
    end
  end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          SR_W       = 32,
  parameter int          INSN_BYTES = 4,
  parameter int          VEC_SHIFT  = 8,
  parameter logic [31:0] VEC_HIGH   = 32'hF000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] req_code,
  input  logic [ADDR_W-1:0] req_ea,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              in_dslot,
  input  logic              dbg_suppress,
  input  logic [SR_W-1:0]   sr_in,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] npc_o,
  output logic [SR_W-1:0]   sr_o,
  output logic [ADDR_W-1:0] epcr_o,
  output logic [ADDR_W-1:0] eear_o,
  output logic [SR_W-1:0]   esr_o,
  output logic              dslot_o,
  output logic              pending_o
);

  localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(INSN_BYTES);
  localparam logic [ADDR_W-1:0] HIGH_BASE = ADDR_W'(VEC_HIGH);

  exc_class_t        cls;
  logic              ret_we;
  logic [ADDR_W-1:0] ret_addr;
  logic [SR_W-1:0]   sr_entry;
  logic [ADDR_W-1:0] vec_off;
  logic [ADDR_W-1:0] vector;
  logic              accept;

  exc_class_decode u_decode (
    .code (req_code),
    .cls  (cls)
  );

  exc_ret_addr #(
    .ADDR_W     (ADDR_W),
    .INSN_BYTES (INSN_BYTES)
  ) u_ret (
    .src      (cls.ret_src),
    .ea       (req_ea),
    .pc       (cur_pc),
    .dslot    (in_dslot),
    .wr_en    (ret_we),
    .ret_addr (ret_addr)
  );

  exc_sr_rewrite #(
    .SR_W (SR_W)
  ) u_sr (
    .sr_cur (sr_in),
    .sr_new (sr_entry)
  );

  always_comb begin
    vec_off = ADDR_W'(req_code) << VEC_SHIFT;
    vector  = (sr_in[SRB_VHIGH] ? HIGH_BASE : '0) + vec_off;
    accept  = req_valid && !dbg_suppress && cls.known;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o      <= '0;
      npc_o     <= '0;
      sr_o      <= '0;
      epcr_o    <= '0;
      eear_o    <= '0;
      esr_o     <= '0;
      dslot_o   <= 1'b0;
      pending_o <= 1'b0;
    end else begin
      pending_o <= accept;
      dslot_o   <= accept ? 1'b0 : in_dslot;
      if (accept) begin
        eear_o <= req_ea;
        esr_o  <= sr_in;
        sr_o   <= sr_entry;
        if (ret_we) begin
          epcr_o <= ret_addr;
        end
        if (cls.async_irq) begin
          pc_o  <= vector;
          npc_o <= vector + STEP;
        end else begin
          pc_o  <= cur_pc;
          npc_o <= vector;
        end
      end
    end
  end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SR_W   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [CODE_W-1:0] req_code,
  input logic [ADDR_W-1:0] req_ea,
  input logic              dbg_suppress,
  input logic [SR_W-1:0]   sr_in,
  input logic [ADDR_W-1:0] epcr_o,
  input logic [ADDR_W-1:0] eear_o,
  input logic [SR_W-1:0]   esr_o,
  input logic [SR_W-1:0]   sr_o,
  input logic              dslot_o,
  input logic              pending_o
);

  p_eear_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !dbg_suppress && req_code == XC_BUS) |=> (eear_o == $past(req_ea)));

  p_esr_snapshot_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !dbg_suppress && req_code == XC_TRAP) |=> (esr_o == $past(sr_in)));

  p_supervisor_entry_r3: assert property (@(posedge clk) disable iff (rst)
    pending_o |-> (sr_o[SRB_SUPV] && !sr_o[SRB_INTE] && !sr_o[SRB_TICKE] &&
                   !sr_o[SRB_DMMU] && !sr_o[SRB_IMMU] && !sr_o[SRB_OVFE]));

  p_reset_keeps_epcr_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_code == XC_RESET) |=> $stable(epcr_o));

  p_dslot_cleared_r9: assert property (@(posedge clk) disable iff (rst)
    pending_o |-> !dslot_o);

  p_veto_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && dbg_suppress) |=> (!pending_o && $stable(sr_o) && $stable(eear_o) && $stable(epcr_o)));

  p_unknown_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_code == 4'h0 || req_code == 4'hD || req_code == 4'hF)) |=>
      (!pending_o && $stable(esr_o)));

  p_pending_needs_req_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(pending_o) |-> $past(req_valid));

endmodule

bind exc_entry_unit exc_entry_chk #(
  .ADDR_W (ADDR_W),
  .SR_W   (SR_W)
) i_exc_entry_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_code     (req_code),
  .req_ea       (req_ea),
  .dbg_suppress (dbg_suppress),
  .sr_in        (sr_in),
  .epcr_o       (epcr_o),
  .eear_o       (eear_o),
  .esr_o        (esr_o),
  .sr_o         (sr_o),
  .dslot_o      (dslot_o),
  .pending_o    (pending_o)
);

// File: tb/test_exc_entry_unit.sv
`timescale 1ns/1ps
module test_exc_entry_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [3:0]  req_code;
  logic [31:0] req_ea;
  logic [31:0] cur_pc;
  logic        in_dslot;
  logic        dbg_suppress;
  logic [31:0] sr_in;
  logic [31:0] pc_o, npc_o, sr_o, epcr_o, eear_o, esr_o;
  logic        dslot_o, pending_o;

  int checks = 0;
  int failures = 0;

  // bench model of the architectural state
  logic [31:0] m_pc, m_npc, m_sr, m_epcr, m_eear, m_esr;

  always #2.5 clk = ~clk;

  exc_entry_unit i_exc_entry_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_code(req_code),
    .req_ea(req_ea), .cur_pc(cur_pc), .in_dslot(in_dslot),
    .dbg_suppress(dbg_suppress), .sr_in(sr_in), .pc_o(pc_o), .npc_o(npc_o),
    .sr_o(sr_o), .epcr_o(epcr_o), .eear_o(eear_o), .esr_o(esr_o),
    .dslot_o(dslot_o), .pending_o(pending_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] handler(input logic [3:0] c, input logic [31:0] s);
    return (s[14] ? 32'hF000_0000 : 32'h0) + ({28'h0, c} << 8);
  endfunction

  function automatic string ret_tag(input logic [3:0] c);
    case (c)
      4'h1:       return "R4";
      4'h4, 4'hA: return "R5";
      4'hC:       return "R7";
      4'h5, 4'h8: return "R8";
      default:    return "R6";
    endcase
  endfunction

  // drive one request, update the model from the requirements, compare all ports
  task automatic entry(input logic [3:0] c, input logic [31:0] ea, input logic [31:0] pc,
                       input logic ds, input logic [31:0] s, input logic veto,
                       input string quiet_tag);
    logic known, take;
    logic [31:0] v, dec;
    known = !(c == 4'h0 || c == 4'hD || c == 4'hF);
    take  = known && !veto;
    v     = handler(c, s);
    dec   = ds ? 32'd4 : 32'd0;
    @(negedge clk);
    req_valid = 1'b1; req_code = c; req_ea = ea; cur_pc = pc;
    in_dslot = ds; dbg_suppress = veto; sr_in = s;
    @(negedge clk);
    req_valid = 1'b0; in_dslot = 1'b0; dbg_suppress = 1'b0;
    if (take) begin
      m_eear = ea; m_esr = s;
      m_sr = (s | 32'h1) & ~32'h0000_1066;
      case (c)
        4'h1: ;
        4'h4, 4'hA: m_epcr = ea - dec;
        4'hC: m_epcr = pc + 32'd4 - dec;
        default: m_epcr = pc - dec;
      endcase
      if (c == 4'h5 || c == 4'h8) begin m_pc = v; m_npc = v + 32'd4; end
      else begin m_pc = pc; m_npc = v; end
      chk("R12 pending", {31'h0, pending_o}, 32'h1);
      chk("R2 eear", eear_o, m_eear);
      chk("R2 esr", esr_o, m_esr);
      chk("R3 sr", sr_o, m_sr);
      chk({ret_tag(c), " epcr"}, epcr_o, m_epcr);
      chk((c == 4'h5 || c == 4'h8) ? "R8 pc" : "R1 pc", pc_o, m_pc);
      chk((c == 4'h5 || c == 4'h8) ? "R8 npc" : "R1 npc", npc_o, m_npc);
      chk("R9 dslot cleared", {31'h0, dslot_o}, 32'h0);
    end else begin
      chk({quiet_tag, " pending"}, {31'h0, pending_o}, 32'h0);
      chk({quiet_tag, " eear"}, eear_o, m_eear);
      chk({quiet_tag, " esr"}, esr_o, m_esr);
      chk({quiet_tag, " sr"}, sr_o, m_sr);
      chk({quiet_tag, " epcr"}, epcr_o, m_epcr);
      chk({quiet_tag, " pc"}, pc_o, m_pc);
      chk({quiet_tag, " npc"}, npc_o, m_npc);
    end
    @(negedge clk);
    chk("R12 pending single cycle", {31'h0, pending_o}, 32'h0);
  endtask

  task automatic t_reset_state;
    chk("R12 reset pc", pc_o, 0);
    chk("R12 reset npc", npc_o, 0);
    chk("R12 reset sr", sr_o, 0);
    chk("R12 reset epcr", epcr_o, 0);
    chk("R12 reset eear", eear_o, 0);
    chk("R12 reset esr", esr_o, 0);
    chk("R12 reset flags", {30'h0, dslot_o, pending_o}, 0);
  endtask

  task automatic t_sync_faults;
    logic [3:0] list [7] = '{4'h2, 4'h3, 4'h6, 4'h7, 4'h9, 4'hB, 4'hE};
    for (int i = 0; i < 7; i++) begin
      entry(list[i], 32'h0000_8000 + i, 32'h0000_2000 + 32'(i * 16), i[0], 32'h0000_1067, 1'b0, "R6");
    end
  endtask

  task automatic t_fetch_faults;
    entry(4'h4, 32'h0001_0040, 32'h0000_3000, 1'b0, 32'h0000_0064, 1'b0, "R5");
    entry(4'hA, 32'h0001_0044, 32'h0000_3004, 1'b1, 32'h0000_0064, 1'b0, "R5");
  endtask

  task automatic t_syscall;
    entry(4'hC, 32'h0, 32'h0000_4010, 1'b0, 32'h8000_0006, 1'b0, "R7");
    entry(4'hC, 32'h0, 32'h0000_4010, 1'b1, 32'h8000_0006, 1'b0, "R7");
  endtask

  task automatic t_interrupts;
    entry(4'h5, 32'h0, 32'h0000_5000, 1'b0, 32'h0000_0006, 1'b0, "R8");
    entry(4'h8, 32'h0, 32'h0000_5008, 1'b1, 32'h0000_4006, 1'b0, "R8");
  endtask

  task automatic t_high_vectors;
    entry(4'h7, 32'h0000_0000, 32'h0000_0000, 1'b1, 32'hFFFF_FFFE, 1'b0, "R1");
    entry(4'hE, 32'h1234_5678, 32'h0000_6000, 1'b0, 32'h0000_4000, 1'b0, "R1");
  endtask

  task automatic t_reset_code;
    entry(4'h1, 32'hDEAD_0000, 32'h0000_7000, 1'b0, 32'h0000_0000, 1'b0, "R4");
  endtask

  task automatic t_veto;
    entry(4'h2, 32'hAAAA_0000, 32'h0000_9000, 1'b1, 32'h0000_0004, 1'b1, "R10");
    entry(4'h8, 32'hAAAA_0004, 32'h0000_9004, 1'b0, 32'h0000_0004, 1'b1, "R10");
  endtask

  task automatic t_unknown;
    entry(4'h0, 32'hBBBB_0000, 32'h0000_A000, 1'b0, 32'h0000_0004, 1'b0, "R11");
    entry(4'hD, 32'hBBBB_0004, 32'h0000_A004, 1'b0, 32'h0000_0004, 1'b0, "R11");
    entry(4'hF, 32'hBBBB_0008, 32'h0000_A008, 1'b0, 32'h0000_0004, 1'b0, "R11");
  endtask

  task automatic t_dslot_follow;
    @(negedge clk);
    in_dslot = 1'b1;
    @(negedge clk);
    chk("R9 dslot follows input", {31'h0, dslot_o}, 32'h1);
    in_dslot = 1'b0;
    @(negedge clk);
    chk("R9 dslot follows input low", {31'h0, dslot_o}, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_code = '0; req_ea = '0; cur_pc = '0;
    in_dslot = 1'b0; dbg_suppress = 1'b0; sr_in = '0;
    m_pc = '0; m_npc = '0; m_sr = '0; m_epcr = '0; m_eear = '0; m_esr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_sync_faults();
    t_fetch_faults();
    t_syscall();
    t_interrupts();
    t_high_vectors();
    t_reset_code();
    t_veto();
    t_unknown();
    t_dslot_follow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule